// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block stretches processor bus cycles so that slow memory or peripherals can keep up. A strobe marks the start of every machine cycle, and a flag on the same clock marks that cycle as an opcode fetch. When a cycle starts, the block takes a snapshot of two static settings and holds its wait request high for that many clock periods. One setting is a wait count (0 to 3) applied to every machine cycle. The other is a single extra wait (0 or 1) added only to opcode-fetch cycles, where the access window is tightest. One wait state lasts exactly one processor clock period, so the same settings give 250 ns per state at 4 MHz and 500 ns per state at 2 MHz.

An external ready input, active high, can keep the processor waiting beyond the programmed count. The output wait request is the OR of the internal countdown and a low external ready. With both settings at zero, no wait states are inserted.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset the internal count is zero, and `wait_req` is low whenever `ext_rdy` is high and no cycle has started.
- R2: A cycle start sampled at a rising edge with `cyc_fetch` low makes `wait_req` high for exactly `wait_sel` clock periods, beginning right after that edge, with `ext_rdy` held high.
- R3: On a cycle start with `cyc_fetch` high, the number of wait periods is `wait_sel + fetch_sel`.
- R4: `fetch_sel` has no effect on a cycle whose start has `cyc_fetch` low.
- R5: The largest setting, `wait_sel` = 3 with `fetch_sel` = 1 on a fetch, gives exactly 4 wait periods, and the count never exceeds 4.
- R6: The settings and the fetch flag are sampled only at the cycle-start edge. Changing them later in the cycle does not change the current cycle's wait length.
- R7: While `ext_rdy` is low, `wait_req` is high in the same cycle, whatever the count.
- R8: With both settings at zero, a cycle start of either kind produces no wait period.
- R9: A new cycle start while waits remain discards the old count and loads the new cycle's count.
- R10: Without a cycle start, a nonzero count falls by exactly one per clock until it reaches zero, and then stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; one wait state equals one period |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | High for one clock at the start of a machine cycle |
| cyc_fetch | input | 1 | High with `cyc_start` when the cycle is an opcode fetch |
| wait_sel | input | W_BITS (2) | Wait states added to every machine cycle |
| fetch_sel | input | F_BITS (1) | Extra wait states added to opcode-fetch cycles only |
| ext_rdy | input | 1 | External ready; low holds the processor waiting |
| wait_req | output | 1 | Combined wait request to the processor, high means wait |

## Verification
The bench goes after the off-by-one edges of the countdown. A design that loads one too many or one too few periods, or that starts waiting a cycle late, gives the wrong number of high cycles for a given setting. It applies the fetch extra to a non-fetch cycle and changes the settings in the middle of a cycle: a design that adds the extra wait to every cycle, or that reads the settings each clock, stretches or shortens that cycle. It restarts a cycle while waits remain, which catches a design that adds the new count to the old one. It also drops external ready while the count is zero, which exposes a wait request that only follows the counter.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  // Largest wait total from a per-cycle field and a fetch-only field.
  function automatic int max_waits(input int w_bits, input int f_bits);
    return ((1 << w_bits) - 1) + ((1 << f_bits) - 1);
  endfunction

  // Bits needed to hold values 0..maxv.
  function automatic int count_width(input int maxv);
    int w;
    w = 1;
    while ((1 << w) <= maxv) w++;
    return w;
  endfunction

endpackage

// File: rtl/bwg_load_calc.sv
module bwg_load_calc #(
  parameter int W_BITS = 2,
  parameter int F_BITS = 1,
  parameter int CNT_W  = 3
) (
  input  logic              cyc_fetch,
  input  logic [W_BITS-1:0] wait_sel,
  input  logic [F_BITS-1:0] fetch_sel,
  output logic [CNT_W-1:0]  load_val
);

  // Total waits for one machine cycle: base count, plus fetch extra on fetches.
  function automatic logic [CNT_W-1:0] total_waits(
    input logic              fetch,
    input logic [W_BITS-1:0] base,
    input logic [F_BITS-1:0] extra
  );
    logic [CNT_W-1:0] add;
    add = fetch ? CNT_W'(extra) : '0;
    return CNT_W'(base) + add;
  endfunction

  assign load_val = total_waits(cyc_fetch, wait_sel, fetch_sel);

endmodule

// File: rtl/bwg_counter.sv
module bwg_counter #(
  parameter int CNT_W     = 3,
  parameter int MAX_WAITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             counting
);

  logic load_evt;
  logic dec_evt;

  assign load_evt = cyc_start;
  assign dec_evt  = !cyc_start && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load_evt) cnt <= load_val;
    else if (dec_evt)  cnt <= cnt - 1'b1;
  end

  assign counting = (cnt != '0);

  // R2 / R3 / R9: a cycle start replaces the count with the new total
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(load_val));

  // R10: one step down per clock while waits remain
  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> cnt == $past(cnt) - 1'b1);

  // R1 / R10: an empty count stays empty without a start
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && cnt == '0) |=> cnt == '0);

  // R5: the count never exceeds the largest legal total
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_WAITS));

endmodule

// File: rtl/bwg_ready_merge.sv
module bwg_ready_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic counting,
  input  logic ext_rdy,
  output logic wait_req
);

  assign wait_req = counting || !ext_rdy;

  // R7: a low external ready always holds the processor
  assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rdy |-> wait_req);

  // R1 / R2: with no count and ready high, the processor runs
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && ext_rdy) |-> !wait_req);

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int W_BITS = 2,
  parameter int F_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_fetch,
  input  logic [W_BITS-1:0] wait_sel,
  input  logic [F_BITS-1:0] fetch_sel,
  input  logic              ext_rdy,
  output logic              wait_req
);

  localparam int MAX_WAITS = bwg_pkg::max_waits(W_BITS, F_BITS);
  localparam int CNT_W     = bwg_pkg::count_width(MAX_WAITS);

  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             counting;

  bwg_load_calc #(
    .W_BITS(W_BITS),
    .F_BITS(F_BITS),
    .CNT_W (CNT_W)
  ) u_load (
    .cyc_fetch(cyc_fetch),
    .wait_sel (wait_sel),
    .fetch_sel(fetch_sel),
    .load_val (load_val)
  );

  bwg_counter #(
    .CNT_W    (CNT_W),
    .MAX_WAITS(MAX_WAITS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .load_val (load_val),
    .cnt      (cnt),
    .counting (counting)
  );

  bwg_ready_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .counting(counting),
    .ext_rdy (ext_rdy),
    .wait_req(wait_req)
  );

  // R4: a non-fetch cycle loads the base setting alone
  assert_nofetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_fetch) |=> cnt == CNT_W'($past(wait_sel)));

  // R6: without a start the count never grows, whatever the settings do
  assert_sampled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> cnt <= $past(cnt));

endmodule

// File: tb/bus_wait_gen_tb.sv
module bus_wait_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       cyc_fetch = 1'b0;
  logic [1:0] wait_sel = 2'd0;
  logic [0:0] fetch_sel = 1'b0;
  logic       ext_rdy = 1'b1;
  logic       wait_req;

  int checks = 0;
  int fails = 0;
  int exp_left = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .cyc_fetch(cyc_fetch),
    .wait_sel (wait_sel),
    .fetch_sel(fetch_sel),
    .ext_rdy  (ext_rdy),
    .wait_req (wait_req)
  );

  // Wait periods a cycle should receive, from the requirements.
  function automatic int cycle_waits(input logic fetch, input int base, input int extra);
    if (fetch) return base + extra;
    return base;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wait_req=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one clock of stimulus, update the expected count, check at negedge.
  task automatic tick(input logic st, input logic fe, input int w, input int f,
                      input logic ext, input string tag);
    cyc_start = st;
    cyc_fetch = fe;
    wait_sel  = 2'(w);
    fetch_sel = 1'(f);
    ext_rdy   = ext;
    @(posedge clk);
    if (st) exp_left = cycle_waits(fe, w, f);
    else if (exp_left > 0) exp_left--;
    @(negedge clk);
    check(tag, wait_req, (exp_left != 0) || !ext);
  endtask

  // Start a cycle, then idle long enough for it to drain.
  task automatic run_cycle(input logic fe, input int w, input int f, input string tag);
    tick(1'b1, fe, w, f, 1'b1, tag);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, w, f, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", wait_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_left = 0;
    check("R1 idle", wait_req, 1'b0);

    // R8: default settings give no waits
    run_cycle(1'b0, 0, 0, "R8 plain");
    run_cycle(1'b1, 0, 0, "R8 fetch");

    // R2: each base setting on non-fetch cycles
    for (int w = 0; w < 4; w++) run_cycle(1'b0, w, 0, "R2 base");

    // R3: fetch extra added
    run_cycle(1'b1, 1, 1, "R3 fetch");
    run_cycle(1'b1, 0, 1, "R3 fetch");

    // R4: fetch extra ignored on non-fetch cycles
    run_cycle(1'b0, 2, 1, "R4 nofetch");
    run_cycle(1'b0, 0, 1, "R4 nofetch");

    // R5: largest total
    run_cycle(1'b1, 3, 1, "R5 max");

    // R6: settings changed mid-cycle are ignored
    tick(1'b1, 1'b0, 3, 0, 1'b1, "R6 sample");
    tick(1'b0, 1'b1, 0, 1, 1'b1, "R6 sample");
    tick(1'b0, 1'b1, 3, 1, 1'b1, "R6 sample");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1, 1, 1'b1, "R6 sample");

    // R7: external ready low with count idle and with count running
    tick(1'b0, 1'b0, 0, 0, 1'b0, "R7 ext idle");
    tick(1'b0, 1'b0, 0, 0, 1'b0, "R7 ext idle");
    tick(1'b0, 1'b0, 0, 0, 1'b1, "R7 ext release");
    tick(1'b1, 1'b0, 1, 0, 1'b0, "R7 ext count");
    tick(1'b0, 1'b0, 1, 0, 1'b0, "R7 ext hold");
    tick(1'b0, 1'b0, 1, 0, 1'b1, "R7 ext release");

    // R9: restart while waits remain
    tick(1'b1, 1'b1, 3, 1, 1'b1, "R9 restart");
    tick(1'b0, 1'b0, 0, 0, 1'b1, "R9 restart");
    tick(1'b1, 1'b0, 1, 0, 1'b1, "R9 restart");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 0, 0, 1'b1, "R9 restart");

    // R10: constrained random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic st, fe, ext;
      int w, f;
      st  = ($urandom % 4) == 0;
      fe  = $urandom % 2;
      w   = $urandom % 4;
      f   = $urandom % 2;
      ext = ($urandom % 8) != 0;
      tick(st, fe, w, f, ext, "R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule